// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a parameterised set of interrupt sources, up to 32, and folds them into one registered request line towards a processor. Each source is fixed at build time as edge-capturing or level-following by one bit of a mask parameter. When a source fires, its latched status bit is set. Software controls the block through a small 32-bit register window. A single word address selects one of eight registers. A write strobe with data changes state. Read data appears on the clock edge after the address is presented.

Software masks sources through an enable register. It can overwrite that register in full, or change single bits through a set alias and a clear alias. It clears latched events by writing ones to an acknowledge register, and reads a vector register to find which source to service first. Two bits in a global control register, a master enable and a hardware-request enable, both gate the request line. Neither bit changes the latching of events.

Top module: `vic_top`

## Requirements
- R1: After a synchronous reset the status, enable and global control registers are all zero, the request output `irq_o` is low and `rd_data` is zero.
- R2: A write to word 2 (enable) replaces every enable bit with the low data bits. Writing 0 masks every source.
- R3: A write to word 4 (set-enable) sets each enable bit whose data bit is 1 and keeps every other enable bit.
- R4: A write to word 5 (clear-enable) clears each enable bit whose data bit is 1 and keeps every other enable bit.
- R5: A write to word 3 (acknowledge) clears each status bit whose data bit is 1, and all ones clears every status bit. A new event on a source in the same cycle as its acknowledge leaves that status bit set.
- R6: A source whose bit in `EDGE_MASK` is 1 sets its status bit only on a 0-to-1 change against its value one cycle earlier. A source held high does not set the bit again after an acknowledge.
- R7: A source whose bit in `EDGE_MASK` is 0 sets its status bit in every cycle it is high, so an acknowledge while it is still high leaves the bit set.
- R8: Word 0 reads the status bits and word 1 reads pending, which is status AND enable.
- R9: `irq_o` is high, one cycle after the state that causes it, exactly when any pending bit is set and global control bit 0 (master enable) and bit 1 (hardware-request enable) are both 1.
- R10: Word 6 (vector) reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when no source is pending.
- R11: Words 3, 4 and 5 read as zero. Word 7 reads the two global control bits in bits 1:0 and zero above, and only those two bits are stored on a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Interrupt source lines |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the address of the previous cycle |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Two things can reach the same status bit in one clock: an acknowledge write that clears it, and a new source event that sets it. The bench drives an edge-capturing source from low to high at the same clock edge that an acknowledge write for that bit takes effect. It then reads the status word and expects the bit to stay set. A second acknowledge with the source still high must then clear the bit for good. The same rule, that setting wins over clearing, is checked on a level source held high through an acknowledge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_DW = 32;
  localparam int VIC_AW = 3;

  typedef enum logic [VIC_AW-1:0] {
    REG_STAT   = 3'd0,
    REG_PEND   = 3'd1,
    REG_EN     = 3'd2,
    REG_ACK    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_VEC    = 3'd6,
    REG_MASTER = 3'd7
  } vic_reg_e;
endpackage

// File: rtl/vic_src_cell.sv
// Per-source event detector: edge variant compares against a registered copy.
module vic_src_cell #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  output logic set_o
);
  generate
    if (EDGE) begin : g_edge
      logic src_q;
      always_ff @(posedge clk) begin
        if (rst) src_q <= 1'b0;
        else     src_q <= src_i;
      end
      assign set_o = src_i & ~src_q;

      AST_EDGE_ONESHOT: assert property (@(posedge clk) disable iff (rst)
        set_o |=> !set_o); // R6
    end else begin : g_level
      assign set_o = src_i;
    end
  endgenerate
endmodule

// File: rtl/vic_prio_enc.sv
// Lowest-index-first priority encoder over the pending vector.
module vic_prio_enc #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

  always_comb begin
    if (any_o) begin
      AST_VEC_LOWEST: assert (pend_i[idx_o] &&
        ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0)); // R10
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int             N_SRC     = 8,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0,
  localparam int            IW        = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_wr,
  input  logic [VIC_AW-1:0] bus_addr,
  input  logic [VIC_DW-1:0] bus_wdata,
  output logic [VIC_DW-1:0] rd_data,
  output logic              irq_o
);
  logic [N_SRC-1:0]  status_q, enable_q, set_v, ack_m, pend;
  logic              me_q, hie_q, irq_q, pr_any;
  logic [IW-1:0]     pr_idx;
  logic [VIC_DW-1:0] rd_q, rd_nxt;
  logic [N_SRC-1:0]  wmask;
  logic              unused_bits;

  vic_reg_e sel;
  assign sel         = vic_reg_e'(bus_addr);
  assign wmask       = bus_wdata[N_SRC-1:0];
  assign unused_bits = ^bus_wdata;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      vic_src_cell #(.EDGE(EDGE_MASK[g])) cell_i (
        .clk   (clk),
        .rst   (rst),
        .src_i (src_i[g]),
        .set_o (set_v[g])
      );
    end
  endgenerate

  assign ack_m = (bus_wr && sel == REG_ACK) ? wmask : '0;
  assign pend  = status_q & enable_q;

  vic_prio_enc #(.N(N_SRC)) enc_i (
    .pend_i (pend),
    .any_o  (pr_any),
    .idx_o  (pr_idx)
  );

  always_comb begin
    rd_nxt = '0;
    unique case (sel)
      REG_STAT:   rd_nxt[N_SRC-1:0] = status_q;
      REG_PEND:   rd_nxt[N_SRC-1:0] = pend;
      REG_EN:     rd_nxt[N_SRC-1:0] = enable_q;
      REG_VEC:    if (pr_any) rd_nxt[IW-1:0] = pr_idx;
                  else        rd_nxt = '1;
      REG_MASTER: rd_nxt[1:0] = {hie_q, me_q};
      default:    rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      me_q     <= 1'b0;
      hie_q    <= 1'b0;
      irq_q    <= 1'b0;
      rd_q     <= '0;
    end else begin
      status_q <= (status_q & ~ack_m) | set_v;
      if (bus_wr) begin
        case (sel)
          REG_EN:     enable_q <= wmask;
          REG_SETEN:  enable_q <= enable_q | wmask;
          REG_CLREN:  enable_q <= enable_q & ~wmask;
          REG_MASTER: {hie_q, me_q} <= bus_wdata[1:0];
          default:    ;
        endcase
      end
      irq_q <= (|pend) & me_q & hie_q;
      rd_q  <= rd_nxt;
    end
  end

  assign rd_data = rd_q;
  assign irq_o   = irq_q;

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == REG_ACK) |=> ((status_q & $past(wmask & ~set_v)) == '0)); // R5
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == REG_SETEN) |=> ((enable_q & $past(wmask)) == $past(wmask))); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == REG_CLREN) |=> ((enable_q & $past(wmask)) == '0)); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(me_q && hie_q && (pend != '0))); // R9
endmodule

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] src = '0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vic_top #(.N_SRC(N), .EDGE_MASK(8'hF0)) dut_i (
    .clk(clk), .rst(rst), .src_i(src), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .rd_data(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{3'd2, 32'h0000_00A5, 3'd2, 32'h0000_00A5}, // R2 replace
    '{3'd4, 32'h0000_000A, 3'd2, 32'h0000_00AF}, // R3 set alias
    '{3'd5, 32'h0000_0021, 3'd2, 32'h0000_008E}, // R4 clear alias
    '{3'd4, 32'h0000_0000, 3'd4, 32'h0000_0000}, // R11 set alias reads 0
    '{3'd5, 32'h0000_0000, 3'd5, 32'h0000_0000}, // R11 clear alias reads 0
    '{3'd3, 32'h0000_00FF, 3'd3, 32'h0000_0000}, // R11 ack reads 0
    '{3'd2, 32'h0000_0000, 3'd2, 32'h0000_0000}, // R2 write 0 masks all
    '{3'd7, 32'h0000_0003, 3'd7, 32'h0000_0003}, // R11 global control
    '{3'd7, 32'hFFFF_FFFD, 3'd7, 32'h0000_0001}, // R11 only two bits stored
    '{3'd7, 32'h0000_0000, 3'd7, 32'h0000_0000}, // R11
    '{3'd2, 32'h0000_0000, 3'd6, 32'hFFFF_FFFF}  // R10 none pending
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    wr = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rd_data", rdata, 32'd0);
    bus_read(3'd0, v); check("R1 status", v, 32'd0);
    bus_read(3'd2, v); check("R1 enable", v, 32'd0);
    bus_read(3'd7, v); check("R1 global", v, 32'd0);

    for (int i = 0; i < 11; i++) begin
      bus_write(TBL[i].wa, TBL[i].wd);
      bus_read(TBL[i].ra, v);
      check($sformatf("table %0d (R2 R3 R4 R10 R11)", i), v, TBL[i].ex);
    end

    // R7 / R8 level source latches, masked so not pending
    src[1] = 1'b1; idle(2);
    bus_read(3'd0, v); check("R7 level sets status", v, 32'h02);
    bus_read(3'd1, v); check("R8 pending masked", v, 32'h00);
    check("R9 irq low", {31'd0, irq}, 32'd0);

    // R9 gating by both global bits
    bus_write(3'd2, 32'h02);
    bus_read(3'd1, v); check("R8 pending", v, 32'h02);
    idle(2); check("R9 both off", {31'd0, irq}, 32'd0);
    bus_write(3'd7, 32'h1); idle(2); check("R9 only master", {31'd0, irq}, 32'd0);
    bus_write(3'd7, 32'h2); idle(2); check("R9 only hw", {31'd0, irq}, 32'd0);
    bus_write(3'd7, 32'h3); idle(2); check("R9 both on", {31'd0, irq}, 32'd1);

    // R10 vector priority
    src[5] = 1'b1;
    bus_write(3'd4, 32'h20);
    bus_read(3'd6, v); check("R10 lowest is 1", v, 32'd1);
    src[1] = 1'b0;
    bus_write(3'd3, 32'h02);
    bus_read(3'd0, v); check("R5 ack one bit", v, 32'h20);
    bus_read(3'd6, v); check("R10 next is 5", v, 32'd5);
    check("R9 still high", {31'd0, irq}, 32'd1);

    // R6 edge source held high does not re-latch
    bus_write(3'd3, 32'h20);
    bus_read(3'd0, v); check("R6 held edge cleared", v, 32'h00);
    idle(2); check("R9 drops", {31'd0, irq}, 32'd0);
    bus_read(3'd6, v); check("R10 none", v, 32'hFFFF_FFFF);

    // R7 level re-latches after ack
    src[2] = 1'b1; idle(2);
    bus_write(3'd3, 32'h04);
    bus_read(3'd0, v); check("R7 level re-sets", v, 32'h04);
    src[2] = 1'b0;
    bus_write(3'd3, 32'hFFFF_FFFF);
    bus_read(3'd0, v); check("R5 ack all ones", v, 32'h00);

    // R5 event and acknowledge in the same cycle
    @(negedge clk);
    src[4] = 1'b1; wr = 1'b1; addr = 3'd3; wdata = 32'h10;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    bus_read(3'd0, v); check("R5 set wins over ack", v, 32'h10);
    bus_write(3'd3, 32'h10);
    bus_read(3'd0, v); check("R6 second ack clears", v, 32'h00);

    // R6 new rising edge re-arms
    src[5] = 1'b0; idle(2); src[5] = 1'b1; idle(2);
    bus_read(3'd0, v); check("R6 new edge", v, 32'h20);
    idle(1); check("R9 irq from edge", {31'd0, irq}, 32'd1);
    bus_write(3'd2, 32'h0); idle(2);
    check("R2 mask all drops irq", {31'd0, irq}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule